// File: doc/BRIEF.md
# Event Channel Generator Selector

This block is one event-routing channel. A write to its selection register connects exactly one of `N_GEN` event generator inputs to the channel outputs. Each generator is given a class at elaboration time. An event is either a pulse or a level, and it is either synchronous to the peripheral clock or asynchronous to it. The class decides how the selected event reaches the channel.

There are two outputs. `evt_sync` is meant for users clocked by the peripheral clock. Synchronous generators reach it combinationally. Asynchronous levels pass through a two-flop synchronizer. Asynchronous pulses come from a foreign clock domain. A pulse of that kind is caught by a toggle flop clocked by `src_clk`, brought across with a synchronizer, and turned back into a single peripheral-clock pulse by an edge detector. `evt_async` carries the raw, unclocked input of the selected generator. It keeps propagating while the peripheral clock is stopped.

After reset the channel is disconnected. When the selection changes, `evt_sync` is held low for two cycles so that stale synchronizer state cannot leak out as a false event. All generators of the asynchronous-pulse class share the one source clock `src_clk`. Default classes are:
- generator 0: synchronous pulse
- generator 1: synchronous level
- generator 2: asynchronous pulse
- generator 3: asynchronous level

Top module: `evt_chan_sel`

## Requirements
- R1: A cycle with `sel_we` high loads `sel_wdata` into the 8-bit selection register at that clock edge. A value v from 1 to `N_GEN` routes generator v-1. The value 0, or any value above `N_GEN`, leaves both `evt_sync` and `evt_async` at 0.
- R2: While reset is asserted and after its release, the selection is 0 and both outputs are 0, whatever the generator inputs are.
- R3: A selected synchronous generator, pulse or level, appears on `evt_sync` in the same cycle, with no register on the path.
- R4: A selected asynchronous level generator appears on `evt_sync` after two rising edges of `clk_per`.
- R5: `evt_async` equals the selected generator's raw input, combinationally, and it follows that input while `clk_per` is stopped.
- R6: The selected asynchronous pulse generator has its pulses spaced at least three `clk_per` periods apart. For it, `evt_sync` gives exactly one pulse of one `clk_per` cycle per source pulse, when `src_clk` is slower than `clk_per` and when it is faster.
- R7: A write that changes the selection forces `evt_sync` to 0 for the two cycles that follow the write edge. A write of the value already held does not interrupt `evt_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_per | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| src_clk | input | 1 | Source clock for the asynchronous pulse generators |
| sel_we | input | 1 | Selection register write strobe |
| sel_wdata | input | SEL_W | Selection value to write |
| gen_evt | input | N_GEN | Event generator inputs, one bit per generator |
| evt_sync | output | 1 | Channel event for peripheral-clock users |
| evt_async | output | 1 | Raw, unclocked channel event |

## Verification
Timing differs by class:
- Synchronous classes and `evt_async` are due in the same cycle as their input, so they are sampled one nanosecond after the input is driven at a falling edge.
- An asynchronous level is due after the second rising edge, so the bench samples it at the falling edges after the first and after the second rising edge.
- A selection write takes effect at its own rising edge. The blanking window covers the two following falling-edge samples, and the third sample shows the live value.
- Asynchronous pulses land two to three edges after their source edge, which is not a fixed cycle. So they are checked by count and width over a whole burst, plus a few settling cycles, rather than at one cycle.

// File: rtl/evt_chan_pkg.sv
`timescale 1ns/1ps
package evt_chan_pkg;

  typedef enum logic [1:0] {
    EVC_SYNC_PULSE  = 2'd0,
    EVC_SYNC_LEVEL  = 2'd1,
    EVC_ASYNC_PULSE = 2'd2,
    EVC_ASYNC_LEVEL = 2'd3
  } evt_class_e;

  function automatic evt_class_e class_of(input logic is_pulse, input logic is_async);
    if (is_async) return is_pulse ? EVC_ASYNC_PULSE : EVC_ASYNC_LEVEL;
    return is_pulse ? EVC_SYNC_PULSE : EVC_SYNC_LEVEL;
  endfunction

endpackage

// File: rtl/evt_rst_sync.sv
`timescale 1ns/1ps
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/evt_sel_ctrl.sv
`timescale 1ns/1ps
module evt_sel_ctrl #(
  parameter int SEL_W     = 8,
  parameter int BLANK_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_data,
  output logic [SEL_W-1:0] sel_q,
  output logic             blank
);

  localparam int CNT_W = $clog2(BLANK_CYC + 1);

  logic [SEL_W-1:0] sel_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             change;

  always_comb begin
    change = wr_en && (wr_data != sel_q);
    sel_d  = change ? wr_data : sel_q;
    if (change)              cnt_d = CNT_W'(BLANK_CYC);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_d;
      cnt_q <= cnt_d;
    end
  end

  assign blank = (cnt_q != '0);

endmodule

// File: rtl/evt_level_sync.sv
`timescale 1ns/1ps
module evt_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/evt_pulse_xing.sv
`timescale 1ns/1ps
module evt_pulse_xing #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_evt,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_pulse
);

  logic            tgl_q;
  logic            tgl_d;
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    tgl_d = tgl_q ^ src_evt;
  end

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], tgl_q};
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sh_q <= '0;
    else            sh_q <= sh_d;
  end

  assign dst_pulse = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/evt_chan_sel.sv
`timescale 1ns/1ps
module evt_chan_sel
  import evt_chan_pkg::*;
#(
  parameter int               N_GEN       = 4,
  parameter int               SEL_W       = 8,
  parameter logic [N_GEN-1:0] GEN_PULSE   = 4'b0101,
  parameter logic [N_GEN-1:0] GEN_ASYNC   = 4'b1100,
  parameter int               SYNC_STAGES = 2,
  parameter int               BLANK_CYC   = 2
) (
  input  logic             clk_per,
  input  logic             rst_n,
  input  logic             src_clk,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  input  logic [N_GEN-1:0] gen_evt,
  output logic             evt_sync,
  output logic             evt_async
);

  logic             per_rst_n;
  logic             src_rst_n;
  logic [SEL_W-1:0] sel_q;
  logic             blank;
  logic [N_GEN-1:0] cond;
  logic             pick_s;
  logic             pick_a;

  evt_rst_sync #(.STAGES(2)) u_per_rst (
    .clk(clk_per), .rst_n_in(rst_n), .rst_n_out(per_rst_n)
  );

  evt_rst_sync #(.STAGES(2)) u_src_rst (
    .clk(src_clk), .rst_n_in(rst_n), .rst_n_out(src_rst_n)
  );

  evt_sel_ctrl #(.SEL_W(SEL_W), .BLANK_CYC(BLANK_CYC)) u_ctrl (
    .clk(clk_per), .rst_n(per_rst_n), .wr_en(sel_we), .wr_data(sel_wdata),
    .sel_q(sel_q), .blank(blank)
  );

  for (genvar g = 0; g < N_GEN; g++) begin : g_gen
    localparam evt_class_e CLS = class_of(GEN_PULSE[g], GEN_ASYNC[g]);
    if (CLS == EVC_ASYNC_PULSE) begin : g_apulse
      evt_pulse_xing #(.STAGES(SYNC_STAGES)) u_xing (
        .src_clk(src_clk), .src_rst_n(src_rst_n), .src_evt(gen_evt[g]),
        .dst_clk(clk_per), .dst_rst_n(per_rst_n), .dst_pulse(cond[g])
      );
    end else if (CLS == EVC_ASYNC_LEVEL) begin : g_alevel
      evt_level_sync #(.STAGES(SYNC_STAGES)) u_lsync (
        .clk(clk_per), .rst_n(per_rst_n), .d(gen_evt[g]), .q(cond[g])
      );
    end else begin : g_direct
      assign cond[g] = gen_evt[g];
    end
  end

  always_comb begin
    pick_s = 1'b0;
    pick_a = 1'b0;
    for (int i = 0; i < N_GEN; i++) begin
      if (sel_q == SEL_W'(i + 1)) begin
        pick_s = cond[i];
        pick_a = gen_evt[i];
      end
    end
  end

  assign evt_sync  = pick_s & ~blank;
  assign evt_async = pick_a;

endmodule

// File: rtl/evt_chan_sel_chk.sv
`timescale 1ns/1ps
module evt_chan_sel_chk #(
  parameter int               N_GEN     = 4,
  parameter int               SEL_W     = 8,
  parameter logic [N_GEN-1:0] GEN_PULSE = 4'b0101,
  parameter logic [N_GEN-1:0] GEN_ASYNC = 4'b1100
) (
  input logic             clk_per,
  input logic             rst_n,
  input logic             sel_we,
  input logic [SEL_W-1:0] sel_wdata,
  input logic [SEL_W-1:0] sel_q,
  input logic             evt_sync,
  input logic             evt_async
);

  logic sel_ok;
  logic sel_apulse;
  logic sel_alevel;

  always_comb begin
    sel_ok     = 1'b0;
    sel_apulse = 1'b0;
    sel_alevel = 1'b0;
    for (int i = 0; i < N_GEN; i++) begin
      if (sel_q == SEL_W'(i + 1)) begin
        sel_ok     = 1'b1;
        sel_apulse = GEN_PULSE[i] & GEN_ASYNC[i];
        sel_alevel = ~GEN_PULSE[i] & GEN_ASYNC[i];
      end
    end
  end

  always @(negedge clk_per) begin
    if (!rst_n) AST_RESET_IDLE: assert (!evt_sync && !evt_async); // R2
  end

  AST_OFF_QUIET: assert property (@(posedge clk_per) disable iff (!rst_n)
    !sel_ok |-> (!evt_sync && !evt_async)); // R1

  AST_SWITCH_BLANK: assert property (@(posedge clk_per) disable iff (!rst_n)
    (sel_we && sel_wdata != sel_q) |=> !evt_sync ##1 !evt_sync); // R7

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_per) disable iff (!rst_n)
    (sel_apulse && $stable(sel_q) && evt_sync) |=> !evt_sync); // R6

  AST_LEVEL_LAG: assert property (@(posedge clk_per) disable iff (!rst_n)
    (sel_alevel && sel_q == $past(sel_q) && sel_q == $past(sel_q, 2) &&
     sel_q == $past(sel_q, 3)) |-> (evt_sync == $past(evt_async, 2))); // R4

endmodule

bind evt_chan_sel evt_chan_sel_chk #(
  .N_GEN(N_GEN), .SEL_W(SEL_W), .GEN_PULSE(GEN_PULSE), .GEN_ASYNC(GEN_ASYNC)
) u_chk (
  .clk_per(clk_per), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
  .sel_q(sel_q), .evt_sync(evt_sync), .evt_async(evt_async)
);

// File: tb/evt_chan_sel_bench.sv
`timescale 1ns/1ps
module evt_chan_sel_bench;

  localparam int N_GEN = 4;
  localparam int NVEC  = 10;

  // vector: {sel[7:0], gen_evt[3:0], exp_sync, exp_async}
  localparam logic [13:0] VEC [NVEC] = '{
    {8'd1,   4'b0001, 1'b1, 1'b1},
    {8'd1,   4'b1010, 1'b0, 1'b0},
    {8'd2,   4'b0010, 1'b1, 1'b1},
    {8'd2,   4'b1001, 1'b0, 1'b0},
    {8'd4,   4'b1000, 1'b1, 1'b1},
    {8'd4,   4'b0011, 1'b0, 1'b0},
    {8'd3,   4'b1011, 1'b0, 1'b0},
    {8'd0,   4'b1011, 1'b0, 1'b0},
    {8'd5,   4'b1011, 1'b0, 1'b0},
    {8'd255, 4'b1011, 1'b0, 1'b0}
  };

  logic             clk_per = 1'b0;
  logic             src_clk = 1'b0;
  logic             clk_run = 1'b1;
  int               src_half = 17;
  logic             rst_n;
  logic             sel_we;
  logic [7:0]       sel_wdata;
  logic [N_GEN-1:0] gen_evt;
  logic             evt_sync;
  logic             evt_async;

  int nchk  = 0;
  int nfail = 0;

  always begin
    #5;
    if (clk_run) clk_per = ~clk_per;
  end

  always begin
    #(src_half);
    src_clk = ~src_clk;
  end

  evt_chan_sel u_evt_chan_sel (
    .clk_per(clk_per), .rst_n(rst_n), .src_clk(src_clk), .sel_we(sel_we),
    .sel_wdata(sel_wdata), .gen_evt(gen_evt), .evt_sync(evt_sync),
    .evt_async(evt_async)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk_per);
    sel_we    = 1'b1;
    sel_wdata = v;
    @(posedge clk_per);
    #1 sel_we = 1'b0;
  endtask

  task automatic run_pulses(input int half, input int n, input string tag);
    int cnt   = 0;
    int wide  = 0;
    int gap   = (half > 5) ? 3 : 7;
    logic prev = 1'b0;
    logic done = 1'b0;
    src_half = half;
    repeat (6) @(negedge clk_per);
    fork
      begin
        repeat (n) begin
          @(negedge src_clk) gen_evt[2] = 1'b1;
          @(negedge src_clk) gen_evt[2] = 1'b0;
          repeat (gap) @(negedge src_clk);
        end
        done = 1'b1;
      end
      begin
        while (!done) begin
          @(negedge clk_per);
          if (evt_sync) cnt++;
          if (evt_sync && prev) wide++;
          prev = evt_sync;
        end
        repeat (6) begin
          @(negedge clk_per);
          if (evt_sync) cnt++;
          if (evt_sync && prev) wide++;
          prev = evt_sync;
        end
      end
    join
    chk({"R6 pulse count ", tag}, cnt, n);
    chk({"R6 pulse width ", tag}, wide, 0);
  endtask

  initial begin
    #150000;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    sel_we    = 1'b0;
    sel_wdata = 8'd3;
    gen_evt   = 4'b1011;
    repeat (3) @(negedge clk_per);
    chk("R2 reset evt_sync", int'(evt_sync), 0);
    chk("R2 reset evt_async", int'(evt_async), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_per);
    chk("R2 idle evt_sync", int'(evt_sync), 0);
    chk("R2 idle evt_async", int'(evt_async), 0);

    // R1 R3 R4 R5: table walk
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][13:6]);
      gen_evt = VEC[k][5:2];
      repeat (4) @(negedge clk_per);
      chk($sformatf("R1 vec %0d evt_sync", k), int'(evt_sync), int'(VEC[k][1]));
      chk($sformatf("R1 vec %0d evt_async", k), int'(evt_async), int'(VEC[k][0]));
    end

    // R3: synchronous pulse passes in the same cycle
    wr(8'd1);
    gen_evt = 4'b0000;
    repeat (3) @(negedge clk_per);
    gen_evt[0] = 1'b1;
    #1 chk("R3 sync pulse same cycle", int'(evt_sync), 1);
    @(negedge clk_per) gen_evt[0] = 1'b0;
    #1 chk("R3 sync pulse ends", int'(evt_sync), 0);

    // R4 R5: asynchronous level lag and raw path
    wr(8'd4);
    repeat (3) @(negedge clk_per);
    gen_evt[3] = 1'b1;
    #1 chk("R5 raw level immediate", int'(evt_async), 1);
    chk("R4 level not yet", int'(evt_sync), 0);
    @(negedge clk_per);
    chk("R4 level after one edge", int'(evt_sync), 0);
    @(negedge clk_per);
    chk("R4 level after two edges", int'(evt_sync), 1);

    // R5: raw path with peripheral clock stopped
    clk_run = 1'b0;
    #20 gen_evt[3] = 1'b0;
    #1 chk("R5 raw falls clock stopped", int'(evt_async), 0);
    #5 gen_evt[3] = 1'b1;
    #1 chk("R5 raw rises clock stopped", int'(evt_async), 1);
    #4 clk_run = 1'b1;

    // R7: blanking on change, none on same-value write
    gen_evt = 4'b0011;
    wr(8'd1);
    repeat (3) @(negedge clk_per);
    wr(8'd2);
    @(negedge clk_per);
    chk("R7 blank cycle 1", int'(evt_sync), 0);
    @(negedge clk_per);
    chk("R7 blank cycle 2", int'(evt_sync), 0);
    @(negedge clk_per);
    chk("R7 live after blank", int'(evt_sync), 1);
    wr(8'd2);
    @(negedge clk_per);
    chk("R7 same value cycle 1", int'(evt_sync), 1);
    @(negedge clk_per);
    chk("R7 same value cycle 2", int'(evt_sync), 1);

    // R6: asynchronous pulses, slow and fast source clocks
    gen_evt = 4'b0000;
    wr(8'd3);
    run_pulses(17, 20, "slow");
    run_pulses(3, 20, "fast");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule